// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration unit of a legacy-bus multi-function I/O device. It sits on a two-byte I/O window. The even address is an index port and the odd address is a data port. Through this pair the host reaches three 8-bit configuration registers. An enable register switches functions on and off and picks alternate base addresses. A mapping register holds packed 2-bit address fields. A power/test register holds power control, the IRQ 5/7 choice, a configuration lock and the EPP mode bit.

Reset values for all three registers are picked from built-in tables by a 5-bit strap input. Just after reset, the index port returns a two-byte identification sequence. From the register contents the block decodes, with no clock delay, the enable, I/O base and IRQ number of a parallel port, two serial ports, a floppy controller and an IDE controller. Downstream logic uses a one-cycle change pulse to re-sample these decoded values. Only byte accesses exist. Read data is registered and is flagged by a one-cycle valid strobe.

Top module: `sio_cfg_port`

## Requirements
- R1: An access hits only when bus_addr matches BASE_ADDR (default 0x398) in all bits except bit 0. Bit 0 = 0 selects the index port and bit 0 = 1 selects the data port. An access outside the window changes no state and raises no bus_rvalid.
- R2: After reset, the first index-port read returns 0x88 and the second returns 0x00. Every later index-port read returns the selected index. An index-port write ends this sequence at once and loads the index.
- R3: A read that hits sets bus_rvalid high for exactly the next cycle, with bus_rdata holding the value. A data-port read returns register 0, 1 or 2 when the index is 0, 1 or 2, and returns 0x00 for any index of 3 or more.
- R4: Reset sets the index to 0, clears bus_rvalid and cfg_changed, and loads the registers from the strap. Values are given as (enable, mapping, power): strap 0 gives (0x4F,0x10,0x00), strap 1 gives (0x4F,0x11,0x00), strap 12 gives (0x0F,0x10,0x00), and strap 31 gives (0x00,0x10,0x02).
- R5: Enable register bits: bit 0 enables the parallel port, bit 1 serial 0, bit 2 serial 1, bit 3 floppy and bit 6 IDE. Bit 5 moves the floppy base from 0x3F0 to 0x370, and bit 7 moves the IDE base from 0x1F0 to 0x170. The IDE alternate base is the IDE base plus 0x206. The floppy IRQ is 6 and the IDE IRQ is 14.
- R6: Mapping bits 1:0 give the parallel base as 0x378, 0x3BC, 0x278 or 0 for codes 0, 1, 2, 3. The IRQ is 7 for code 1, 5 for code 2 and 0 for code 3. For code 0 the IRQ is 7 when power bit 3 is set and 5 otherwise.
- R7: Serial n uses mapping bits [2n+3:2n+2]. Code 0 gives 0x3F8 and code 1 gives 0x2F8. Code 2 gives 0x3E8, 0x338, 0x2E8 or 0x220, and code 3 gives 0x2E8, 0x238, 0x2E0 or 0x228; in both cases mapping bits 7:6 (values 0 to 3) pick the entry.
- R8: Serial n's IRQ is 3 when its code is odd and 4 when it is even.
- R9: epp_en equals power register bit 7.
- R10: Once power register bit 6 is set, data-port writes are ignored until the next reset. Index-port writes still work.
- R11: cfg_changed is high for exactly one cycle, the cycle after a data-port write that updated a register. It stays low for rejected writes (index 3 or more, or locked).
- R12: When a read and a write hit the same port in one cycle, the read returns the value before the write and the write takes full effect. On the index port the write also ends the ID sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap | input | 5 | Reset-value selector |
| bus_addr | input | ADDR_W | I/O address |
| bus_rd | input | 1 | Byte read strobe |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle |
| cfg_changed | output | 1 | One-cycle pulse after an accepted register write |
| par_en | output | 1 | Parallel port enable |
| par_base | output | 16 | Parallel port base |
| par_irq | output | 4 | Parallel port IRQ |
| ser0_en | output | 1 | Serial 0 enable |
| ser0_base | output | 16 | Serial 0 base |
| ser0_irq | output | 4 | Serial 0 IRQ |
| ser1_en | output | 1 | Serial 1 enable |
| ser1_base | output | 16 | Serial 1 base |
| ser1_irq | output | 4 | Serial 1 IRQ |
| fdc_en | output | 1 | Floppy controller enable |
| fdc_base | output | 16 | Floppy controller base |
| fdc_irq | output | 4 | Floppy controller IRQ |
| ide_en | output | 1 | IDE enable |
| ide_base | output | 16 | IDE command block base |
| ide_alt_base | output | 16 | IDE control block base |
| ide_irq | output | 4 | IDE IRQ |
| epp_en | output | 1 | EPP mode enable |

## Verification
A read and a write can land on the same port in the same cycle. On the data port the captured read value and the register update then compete. On the index port the ID-sequence advance and the write that ends it compete. The bench drives both strobes together on each port. It then checks three things: the returned byte is the value before the write, a following read shows the written value, and on the index port the sequence is over (the next read gives the index, not 0x00).

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int BYTE_W  = 8;
  localparam int STRAP_W = 5;
  localparam int IOB_W   = 16;
  localparam int IRQ_W   = 4;
  localparam int NREG    = 3;
  localparam int SER_N   = 2;

  typedef logic [BYTE_W-1:0]  byte_t;
  typedef logic [IOB_W-1:0]   iob_t;
  typedef logic [IRQ_W-1:0]   irq_t;
  typedef logic [STRAP_W-1:0] strap_t;

  typedef enum logic [1:0] {
    ID_HI   = 2'd0,
    ID_LO   = 2'd1,
    ID_DONE = 2'd2
  } id_step_e;

  typedef struct packed {
    byte_t pwr;
    byte_t map;
    byte_t en;
  } cfg_regs_t;

  localparam byte_t IDX_EN  = 8'd0;
  localparam byte_t IDX_MAP = 8'd1;
  localparam byte_t IDX_PWR = 8'd2;
  localparam byte_t NREG_B  = 8'(NREG);
  localparam byte_t CHIP_ID = 8'h88;

  // enable register bit positions
  localparam int EN_PAR     = 0;
  localparam int EN_SER0    = 1;
  localparam int EN_FDC     = 3;
  localparam int EN_FDC_ALT = 5;
  localparam int EN_IDE     = 6;
  localparam int EN_IDE_ALT = 7;
  // power register bit positions
  localparam int PW_IRQ7 = 3;
  localparam int PW_LOCK = 6;
  localparam int PW_EPP  = 7;

  localparam iob_t IDE_ALT_OFS = 16'h0206;
  localparam irq_t FDC_IRQ_N   = 4'd6;
  localparam irq_t IDE_IRQ_N   = 4'd14;

  function automatic byte_t strap_en(strap_t s);
    case (s)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5:                 return 8'h4F;
      5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd11:               return 8'h4B;
      5'd12, 5'd13, 5'd14, 5'd15:                         return 8'h0F;
      5'd16, 5'd17, 5'd18, 5'd19:                         return 8'h49;
      5'd20, 5'd21, 5'd22, 5'd23:                         return 8'h07;
      5'd24, 5'd25, 5'd26, 5'd27, 5'd28, 5'd29:           return 8'h47;
      5'd30:                                              return 8'h08;
      default:                                            return 8'h00;
    endcase
  endfunction

  function automatic byte_t strap_map(strap_t s);
    case (s)
      5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26: return 8'h11;
      5'd3, 5'd14, 5'd22, 5'd27:              return 8'h39;
      5'd4, 5'd15, 5'd23, 5'd28:              return 8'h24;
      5'd5, 5'd29:                            return 8'h38;
      5'd6, 5'd16, 5'd19:                     return 8'h00;
      5'd7, 5'd8, 5'd17, 5'd18:               return 8'h01;
      5'd9:                                   return 8'h09;
      5'd10, 5'd11:                           return 8'h08;
      default:                                return 8'h10;
    endcase
  endfunction

  function automatic byte_t strap_pwr(strap_t s);
    return (s == 5'd31) ? 8'h02 : 8'h00;
  endfunction

  function automatic cfg_regs_t strap_regs(strap_t s);
    cfg_regs_t r;
    r.en  = strap_en(s);
    r.map = strap_map(s);
    r.pwr = strap_pwr(s);
    return r;
  endfunction

  function automatic iob_t par_base_of(logic [1:0] code);
    case (code)
      2'd0:    return 16'h0378;
      2'd1:    return 16'h03BC;
      2'd2:    return 16'h0278;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic iob_t ser_base_of(logic [1:0] code, logic [1:0] col);
    case (code)
      2'd0: return 16'h03F8;
      2'd1: return 16'h02F8;
      2'd2: begin
        case (col)
          2'd0:    return 16'h03E8;
          2'd1:    return 16'h0338;
          2'd2:    return 16'h02E8;
          default: return 16'h0220;
        endcase
      end
      default: begin
        case (col)
          2'd0:    return 16'h02E8;
          2'd1:    return 16'h0238;
          2'd2:    return 16'h02E0;
          default: return 16'h0228;
        endcase
      end
    endcase
  endfunction
endpackage

// File: rtl/sio_cfg_rst_sync.sv
module sio_cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  assign sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/sio_cfg_host.sv
module sio_cfg_host
  import sio_cfg_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0398
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  byte_t             bus_wdata,
  input  byte_t             reg_rd_val,
  output byte_t             bus_rdata,
  output logic              bus_rvalid,
  output byte_t             sel_idx,
  output logic              dat_wr
);
  logic     hit, is_dat;
  logic     idx_rd, idx_wr, any_rd;
  byte_t    idx_q, idx_d;
  id_step_e step_q, step_d;
  byte_t    rdata_q, rdata_d;
  logic     rvalid_q, rvalid_d;
  logic     idx_en, step_en, rdata_en;
  byte_t    id_val;

  assign hit    = (bus_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
  assign is_dat = bus_addr[0];
  assign idx_rd = hit & ~is_dat & bus_rd;
  assign idx_wr = hit & ~is_dat & bus_wr;
  assign dat_wr = hit &  is_dat & bus_wr;
  assign any_rd = hit & bus_rd;

  always_comb begin
    case (step_q)
      ID_HI:   id_val = CHIP_ID;
      ID_LO:   id_val = 8'h00;
      default: id_val = idx_q;
    endcase
  end

  always_comb begin
    idx_d    = idx_q;
    step_d   = step_q;
    idx_en   = 1'b0;
    step_en  = 1'b0;
    if (idx_wr) begin
      idx_d   = bus_wdata;
      idx_en  = 1'b1;
      step_d  = ID_DONE;
      step_en = 1'b1;
    end else if (idx_rd && step_q != ID_DONE) begin
      step_d  = (step_q == ID_HI) ? ID_LO : ID_DONE;
      step_en = 1'b1;
    end
    rdata_en = any_rd;
    rdata_d  = is_dat ? reg_rd_val : id_val;
    rvalid_d = any_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= IDX_EN;
      step_q   <= ID_HI;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (idx_en)   idx_q   <= idx_d;
      if (step_en)  step_q  <= step_d;
      if (rdata_en) rdata_q <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign sel_idx    = idx_q;
  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  strap_t    strap,
  input  logic      dat_wr,
  input  byte_t     sel_idx,
  input  byte_t     wdata,
  output cfg_regs_t cfg,
  output byte_t     rd_val,
  output logic      locked,
  output logic      changed
);
  cfg_regs_t regs_q;
  cfg_regs_t rst_val;
  logic      in_range, accept;
  logic      en_we, map_we, pwr_we;
  logic      changed_q;

  assign rst_val  = strap_regs(strap);
  assign locked   = regs_q.pwr[PW_LOCK];
  assign in_range = (sel_idx < NREG_B);
  assign accept   = dat_wr & in_range & ~locked;
  assign en_we    = accept & (sel_idx == IDX_EN);
  assign map_we   = accept & (sel_idx == IDX_MAP);
  assign pwr_we   = accept & (sel_idx == IDX_PWR);

  always_comb begin
    case (sel_idx)
      IDX_EN:  rd_val = regs_q.en;
      IDX_MAP: rd_val = regs_q.map;
      IDX_PWR: rd_val = regs_q.pwr;
      default: rd_val = 8'h00;
    endcase
  end

  // Strap-selected values are applied while reset is asserted; straps are static.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q    <= rst_val;
      changed_q <= 1'b0;
    end else begin
      if (en_we)  regs_q.en  <= wdata;
      if (map_we) regs_q.map <= wdata;
      if (pwr_we) regs_q.pwr <= wdata;
      changed_q <= accept;
    end
  end

  assign cfg     = regs_q;
  assign changed = changed_q;
endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
  import sio_cfg_pkg::*;
(
  input  cfg_regs_t cfg,
  output logic      par_en,
  output iob_t      par_base,
  output irq_t      par_irq,
  output logic      ser_en   [SER_N],
  output iob_t      ser_base [SER_N],
  output irq_t      ser_irq  [SER_N],
  output logic      fdc_en,
  output iob_t      fdc_base,
  output logic      ide_en,
  output iob_t      ide_base,
  output iob_t      ide_alt_base,
  output logic      epp_en
);
  logic [1:0] par_code;
  logic [1:0] ser_col;

  assign par_code = cfg.map[1:0];
  assign ser_col  = cfg.map[7:6];

  assign par_en   = cfg.en[EN_PAR];
  assign par_base = par_base_of(par_code);

  always_comb begin
    case (par_code)
      2'd0:    par_irq = cfg.pwr[PW_IRQ7] ? 4'd7 : 4'd5;
      2'd1:    par_irq = 4'd7;
      2'd2:    par_irq = 4'd5;
      default: par_irq = 4'd0;
    endcase
  end

  for (genvar g = 0; g < SER_N; g++) begin : g_ser
    logic [1:0] code;
    assign code        = cfg.map[2*g+3 -: 2];
    assign ser_en[g]   = cfg.en[EN_SER0+g];
    assign ser_base[g] = ser_base_of(code, ser_col);
    assign ser_irq[g]  = code[0] ? 4'd3 : 4'd4;
  end

  assign fdc_en       = cfg.en[EN_FDC];
  assign fdc_base     = cfg.en[EN_FDC_ALT] ? 16'h0370 : 16'h03F0;
  assign ide_en       = cfg.en[EN_IDE];
  assign ide_base     = cfg.en[EN_IDE_ALT] ? 16'h0170 : 16'h01F0;
  assign ide_alt_base = ide_base + IDE_ALT_OFS;
  assign epp_en       = cfg.pwr[PW_EPP];
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0398
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        strap,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  output logic              cfg_changed,
  output logic              par_en,
  output logic [15:0]       par_base,
  output logic [3:0]        par_irq,
  output logic              ser0_en,
  output logic [15:0]       ser0_base,
  output logic [3:0]        ser0_irq,
  output logic              ser1_en,
  output logic [15:0]       ser1_base,
  output logic [3:0]        ser1_irq,
  output logic              fdc_en,
  output logic [15:0]       fdc_base,
  output logic [3:0]        fdc_irq,
  output logic              ide_en,
  output logic [15:0]       ide_base,
  output logic [15:0]       ide_alt_base,
  output logic [3:0]        ide_irq,
  output logic              epp_en
);
  logic      rst_s_n;
  byte_t     sel_idx, reg_rd_val;
  logic      dat_wr;
  cfg_regs_t cfg;
  logic      cfg_locked;
  logic      ser_en   [SER_N];
  iob_t      ser_base [SER_N];
  irq_t      ser_irq  [SER_N];

  sio_cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  sio_cfg_host #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_host (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .reg_rd_val (reg_rd_val),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .sel_idx    (sel_idx),
    .dat_wr     (dat_wr)
  );

  sio_cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .strap   (strap),
    .dat_wr  (dat_wr),
    .sel_idx (sel_idx),
    .wdata   (bus_wdata),
    .cfg     (cfg),
    .rd_val  (reg_rd_val),
    .locked  (cfg_locked),
    .changed (cfg_changed)
  );

  sio_cfg_decode u_dec (
    .cfg          (cfg),
    .par_en       (par_en),
    .par_base     (par_base),
    .par_irq      (par_irq),
    .ser_en       (ser_en),
    .ser_base     (ser_base),
    .ser_irq      (ser_irq),
    .fdc_en       (fdc_en),
    .fdc_base     (fdc_base),
    .ide_en       (ide_en),
    .ide_base     (ide_base),
    .ide_alt_base (ide_alt_base),
    .epp_en       (epp_en)
  );

  assign ser0_en   = ser_en[0];
  assign ser0_base = ser_base[0];
  assign ser0_irq  = ser_irq[0];
  assign ser1_en   = ser_en[1];
  assign ser1_base = ser_base[1];
  assign ser1_irq  = ser_irq[1];
  assign fdc_irq   = FDC_IRQ_N;
  assign ide_irq   = IDE_IRQ_N;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0398
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_rvalid,
  input logic              cfg_changed,
  input logic              cfg_locked,
  input logic              epp_en,
  input logic [3:0]        par_irq,
  input logic [3:0]        ser0_irq,
  input logic [3:0]        ser1_irq
);
  logic win;
  assign win = (bus_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);

  // R1 R3
  rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_rd && win));

  // R11
  chg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_changed |-> $past(bus_wr && win && bus_addr[0]));

  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> (cfg_locked && !cfg_changed));

  // R9
  epp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> $stable(epp_en));

  always @(posedge clk) begin
    if (rst_n) begin
      // R6
      par_irq_set_chk: assert (par_irq == 4'd0 || par_irq == 4'd5 || par_irq == 4'd7);
      // R8
      ser_irq_set_chk: assert ((ser0_irq == 4'd3 || ser0_irq == 4'd4) &&
                               (ser1_irq == 4'd3 || ser1_irq == 4'd4));
    end
  end
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_rvalid  (bus_rvalid),
  .cfg_changed (cfg_changed),
  .cfg_locked  (cfg_locked),
  .epp_en      (epp_en),
  .par_irq     (par_irq),
  .ser0_irq    (ser0_irq),
  .ser1_irq    (ser1_irq)
);

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;
  localparam logic [15:0] BASE = 16'h0398;
  localparam logic [15:0] A_IDX = BASE;
  localparam logic [15:0] A_DAT = BASE + 16'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  strap = 5'd1;
  logic [15:0] bus_addr = 16'h0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid, cfg_changed;
  logic        par_en, ser0_en, ser1_en, fdc_en, ide_en, epp_en;
  logic [15:0] par_base, ser0_base, ser1_base, fdc_base, ide_base, ide_alt_base;
  logic [3:0]  par_irq, ser0_irq, ser1_irq, fdc_irq, ide_irq;

  sio_cfg_port uut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] q_exp[$];
  string      q_tag[$];

  logic [7:0] m_idx;
  int         m_step;
  logic [7:0] m_reg [3];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops scoreboard items as read data appears
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R1", "unexpected rvalid", 1, 0);
      end else begin
        automatic logic [7:0] e = q_exp.pop_front();
        automatic string t = q_tag.pop_front();
        check(bus_rdata == e, t, "read data", bus_rdata, e);
      end
    end
  end

  function automatic logic [15:0] e_par_base(logic [1:0] c);
    logic [15:0] t [4] = '{16'h378, 16'h3BC, 16'h278, 16'h000};
    return t[c];
  endfunction

  function automatic logic [15:0] e_ser_base(logic [1:0] c, logic [1:0] col);
    logic [15:0] r0 [4] = '{16'h3E8, 16'h338, 16'h2E8, 16'h220};
    logic [15:0] r1 [4] = '{16'h2E8, 16'h238, 16'h2E0, 16'h228};
    if (c == 2'd0) return 16'h3F8;
    if (c == 2'd1) return 16'h2F8;
    if (c == 2'd2) return r0[col];
    return r1[col];
  endfunction

  task automatic chk_decode();
    logic [7:0] en = m_reg[0], mp = m_reg[1], pw = m_reg[2];
    logic [3:0] pi;
    logic [15:0] ib;
    case (mp[1:0])
      2'd0: pi = pw[3] ? 4'd7 : 4'd5;
      2'd1: pi = 4'd7;
      2'd2: pi = 4'd5;
      default: pi = 4'd0;
    endcase
    ib = en[7] ? 16'h170 : 16'h1F0;
    check(par_en == en[0], "R5", "par_en", par_en, en[0]);
    check(ser0_en == en[1] && ser1_en == en[2], "R5", "ser_en", {ser1_en, ser0_en}, en[2:1]);
    check(fdc_en == en[3] && ide_en == en[6], "R5", "fdc/ide en", {ide_en, fdc_en}, {en[6], en[3]});
    check(fdc_base == (en[5] ? 16'h370 : 16'h3F0), "R5", "fdc_base", fdc_base, en[5] ? 16'h370 : 16'h3F0);
    check(ide_base == ib && ide_alt_base == ib + 16'h206, "R5", "ide bases", ide_alt_base, ib + 16'h206);
    check(fdc_irq == 4'd6 && ide_irq == 4'd14, "R5", "fdc/ide irq", {fdc_irq, ide_irq}, 8'h6E);
    check(par_base == e_par_base(mp[1:0]), "R6", "par_base", par_base, e_par_base(mp[1:0]));
    check(par_irq == pi, "R6", "par_irq", par_irq, pi);
    check(ser0_base == e_ser_base(mp[3:2], mp[7:6]), "R7", "ser0_base", ser0_base, e_ser_base(mp[3:2], mp[7:6]));
    check(ser1_base == e_ser_base(mp[5:4], mp[7:6]), "R7", "ser1_base", ser1_base, e_ser_base(mp[5:4], mp[7:6]));
    check(ser0_irq == (mp[2] ? 4'd3 : 4'd4), "R8", "ser0_irq", ser0_irq, mp[2] ? 3 : 4);
    check(ser1_irq == (mp[4] ? 4'd3 : 4'd4), "R8", "ser1_irq", ser1_irq, mp[4] ? 3 : 4);
    check(epp_en == pw[7], "R9", "epp_en", epp_en, pw[7]);
  endtask

  // driver: one bus cycle, model update, scoreboard push, change-pulse check
  task automatic access(logic [15:0] a, bit rd, bit wr, logic [7:0] wd, string tag);
    bit hit = (a[15:1] == BASE[15:1]);
    bit dat = a[0];
    bit acc;
    logic [7:0] e;
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
    if (dat) e = (m_idx < 8'd3) ? m_reg[m_idx] : 8'h00;
    else     e = (m_step == 0) ? 8'h88 : (m_step == 1) ? 8'h00 : m_idx;
    if (rd && hit) begin q_exp.push_back(e); q_tag.push_back(tag); end
    acc = wr && hit && dat && (m_idx < 8'd3) && !m_reg[2][6];
    if (wr && hit && !dat) begin m_idx = wd; m_step = 2; end
    else if (rd && hit && !dat && m_step < 2) m_step++;
    if (acc) m_reg[m_idx] = wd;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check(cfg_changed == acc, "R11", "cfg_changed", cfg_changed, acc);
  endtask

  task automatic wr_reg(logic [7:0] i, logic [7:0] v, string tag);
    access(A_IDX, 0, 1, i, tag);
    access(A_DAT, 0, 1, v, tag);
  endtask

  task automatic do_reset(logic [4:0] s, logic [7:0] e0, logic [7:0] e1, logic [7:0] e2);
    @(negedge clk);
    rst_n = 1'b0; strap = s;
    m_idx = 8'h00; m_step = 0;
    m_reg[0] = e0; m_reg[1] = e1; m_reg[2] = e2;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(bus_rvalid == 1'b0 && cfg_changed == 1'b0, "R4", "reset outputs", {bus_rvalid, cfg_changed}, 0);
    chk_decode();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R4 R2: strap 1, ID sequence, index 0 after reset
    do_reset(5'd1, 8'h4F, 8'h11, 8'h00);
    access(A_IDX, 1, 0, 0, "R2");
    access(A_IDX, 1, 0, 0, "R2");
    access(A_DAT, 1, 0, 0, "R4");
    access(A_IDX, 1, 0, 0, "R2");
    access(A_IDX, 0, 1, 8'd1, "R4");
    access(A_DAT, 1, 0, 0, "R4");
    access(A_IDX, 0, 1, 8'd2, "R4");
    access(A_DAT, 1, 0, 0, "R4");

    // R4 strap 31, R2 early end, R3 out of range index
    do_reset(5'd31, 8'h00, 8'h10, 8'h02);
    access(A_IDX, 1, 0, 0, "R2");
    access(A_IDX, 0, 1, 8'd5, "R2");
    access(A_IDX, 1, 0, 0, "R2");
    access(A_DAT, 1, 0, 0, "R3");
    access(A_DAT, 0, 1, 8'hAA, "R3");
    access(A_DAT, 1, 0, 0, "R3");
    for (int i = 0; i < 3; i++) begin
      access(A_IDX, 0, 1, 8'(i), "R3");
      access(A_DAT, 1, 0, 0, "R3");
    end
    access(A_IDX, 0, 1, 8'hFF, "R3");
    access(A_DAT, 1, 0, 0, "R3");

    do_reset(5'd0, 8'h4F, 8'h10, 8'h00);
    access(A_DAT, 1, 0, 0, "R4");
    do_reset(5'd12, 8'h0F, 8'h10, 8'h00);
    access(A_DAT, 1, 0, 0, "R4");

    // R1: accesses just outside the window
    access(BASE + 16'd2, 1, 1, 8'h55, "R1");
    access(BASE - 16'd1, 1, 1, 8'h55, "R1");
    access(BASE ^ 16'h0400, 1, 1, 8'h01, "R1");
    access(A_IDX, 1, 0, 0, "R1");
    access(A_DAT, 1, 0, 0, "R1");
    chk_decode();

    // R5 sweep of the enable register
    do_reset(5'd1, 8'h4F, 8'h11, 8'h00);
    access(A_IDX, 0, 1, 8'd0, "R5");
    for (int v = 0; v < 256; v++) begin
      access(A_DAT, 0, 1, 8'(v), "R5");
      chk_decode();
    end
    // R6 R7 R8 sweep of the mapping register, both IRQ 5/7 choices
    for (int p = 0; p < 2; p++) begin
      wr_reg(8'd2, p ? 8'h08 : 8'h00, "R6");
      access(A_IDX, 0, 1, 8'd1, "R7");
      for (int v = 0; v < 256; v++) begin
        access(A_DAT, 0, 1, 8'(v), "R7");
        chk_decode();
      end
    end
    // R9 epp bit
    wr_reg(8'd2, 8'h80, "R9");
    chk_decode();
    wr_reg(8'd2, 8'h00, "R9");
    chk_decode();

    // R12 same-cycle read and write, data port then index port
    access(A_IDX, 0, 1, 8'd1, "R12");
    access(A_DAT, 1, 1, 8'h5A, "R12");
    access(A_DAT, 1, 0, 0, "R12");
    chk_decode();
    do_reset(5'd1, 8'h4F, 8'h11, 8'h00);
    access(A_IDX, 1, 1, 8'd2, "R12");
    access(A_IDX, 1, 0, 0, "R12");
    access(A_DAT, 1, 0, 0, "R12");

    // R10 lock
    wr_reg(8'd2, 8'h40, "R10");
    wr_reg(8'd0, 8'h00, "R10");
    access(A_DAT, 1, 0, 0, "R10");
    wr_reg(8'd2, 8'h00, "R10");
    access(A_DAT, 1, 0, 0, "R10");
    chk_decode();
    do_reset(5'd1, 8'h4F, 8'h11, 8'h00);
    wr_reg(8'd0, 8'h03, "R10");
    access(A_DAT, 1, 0, 0, "R10");
    chk_decode();

    repeat (3) @(negedge clk);
    check(q_exp.size() == 0, "R3", "missing read data", q_exp.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule